// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block is the multiply-accumulate stage of a 16-bit fixed-point DSP datapath. Each cycle in which a valid strobe is raised, it multiplies two 16-bit operands. Depending on the op code, it then loads the product into a 40-bit accumulator, adds the product to the accumulator, or subtracts the product from it. A mode input chooses whether the operands are read as two's-complement or as unsigned numbers.

The accumulator has eight guard bits above a 32-bit product. Long sums can therefore run well past the 32-bit range before they wrap. An overflow flag shows when the value has left the signed 32-bit range. The result is registered at the clock edge that follows the request, and it appears on the output port in the next cycle, so the datapath can use it as an operand at once. A synchronous clear empties the accumulator.

Top module: `mac_unit`

## Requirements
- R1: While reset (`rst_n` low) is held and after it is released, `acc` is zero and `ovf` is low until an operation is issued.
- R2: With `in_valid` high and `op` = 2'b00 (multiply), `acc` holds the 40-bit extended product one cycle later, and the previous contents are discarded.
- R3: With `in_valid` high and `op` = 2'b01 (multiply-add), `acc` becomes the old `acc` plus the extended product one cycle later.
- R4: With `in_valid` high and `op` = 2'b10 (multiply-subtract), `acc` becomes the old `acc` minus the extended product one cycle later.
- R5: With `signed_mode` high, both operands are two's complement and the product is sign-extended to 40 bits. With `signed_mode` low, both operands are unsigned and the product is zero-extended, so a lone multiply leaves bits 39..32 at zero.
- R6: With `clear` high, `acc` is zero one cycle later, whatever `in_valid` and `op` are.
- R7: With `in_valid` low and `clear` low, `acc` is unchanged one cycle later.
- R8: The op code 2'b11 is reserved. Issued with `in_valid` high, it leaves `acc` unchanged.
- R9: `ovf` is high exactly when `acc`, read as a signed 40-bit number, lies outside the range -2^31 to 2^31-1.
- R10: Sums wrap modulo 2^40 in two's complement. No saturation occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issues an operation this cycle |
| op | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 reserved |
| clear | input | 1 | Synchronous accumulator clear, wins over `in_valid` |
| signed_mode | input | 1 | 1: operands two's complement; 0: unsigned |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| acc | output | 40 | Accumulator contents |
| ovf | output | 1 | Accumulator outside signed 32-bit range |

## Verification
The hardest state to reach from the ports is the top of the guard range. The accumulator only nears 2^40 after hundreds of near-full-scale products have piled up. The stimulus therefore runs long chains of unsigned 0xFFFF x 0xFFFF multiply-adds until the sum wraps, and it checks `ovf` as it rises and falls again. It also steps signed -32768 x -32768 products upward to catch the exact cycle where the value leaves the 32-bit range. A sweep over boundary operand pairs in both modes and all three operations covers sign handling.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_RSVD = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  x,
  input  logic [OP_W-1:0]  y,
  input  logic             sgn,
  output logic [ACC_W-1:0] prod_ext
);
  localparam int PW  = 2*OP_W + 2;
  localparam int PAD = ACC_W - PW;

  // One extra top bit per operand lets a single signed multiplier serve both modes (R5)
  function automatic logic [ACC_W-1:0] mult_ext(input logic [OP_W-1:0] p,
                                                 input logic [OP_W-1:0] q,
                                                 input logic s);
    logic signed [OP_W:0] ep, eq;
    logic signed [PW-1:0] r;
    ep = {s & p[OP_W-1], p};
    eq = {s & q[OP_W-1], q};
    r  = PW'(ep) * PW'(eq);
    return {{PAD{r[PW-1]}}, r};
  endfunction

  generate
    if (PAD < 0) begin : g_bad_width
      initial $error("ACC_W too narrow for operand width");
    end
  endgenerate

  assign prod_ext = mult_ext(x, y, sgn);
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub
  import mac_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc_q,
  input  logic [ACC_W-1:0] prod_ext,
  input  mac_op_e          op,
  output logic [ACC_W-1:0] acc_d
);
  // Plain two's-complement wrap, no saturation (R10)
  function automatic logic [ACC_W-1:0] combine(input logic [ACC_W-1:0] old_v,
                                               input logic [ACC_W-1:0] p,
                                               input mac_op_e o);
    case (o)
      OP_MUL:  return p;
      OP_ADD:  return old_v + p;
      OP_SUB:  return old_v - p;
      default: return old_v;
    endcase
  endfunction

  assign acc_d = combine(acc_q, prod_ext, op);
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic             clear,
  input  logic             signed_mode,
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  output logic [ACC_W-1:0] acc,
  output logic             ovf
);
  localparam int PROD_W = 2*OP_W;
  localparam int TOP_W  = ACC_W - PROD_W + 1;

  mac_op_e          op_e;
  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             issue;
  logic [TOP_W-1:0] top_bits;

  assign op_e  = mac_op_e'(op);
  assign issue = in_valid & ~clear;

  mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .x(a), .y(b), .sgn(signed_mode), .prod_ext(prod_ext)
  );

  mac_addsub #(.ACC_W(ACC_W)) u_addsub (
    .acc_q(acc_q), .prod_ext(prod_ext), .op(op_e), .acc_d(acc_d)
  );

  // Clear outranks an issued operation (R6); idle holds (R7)
  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (issue) acc_q <= acc_d;
  end

  // Guard bits plus bit PROD_W-1 must all agree for a 32-bit fit (R9)
  assign top_bits = acc_q[ACC_W-1:PROD_W-1];
  assign ovf      = ~((&top_bits) | ~(|top_bits));
  assign acc      = acc_q;

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clear) |=> $stable(acc));

  a_r8_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear && op == 2'b11) |=> $stable(acc));

  a_r2_mul_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear && op == 2'b00) |=> (acc == $past(prod_ext)));

  a_r3_add_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear && op == 2'b01) |=> (acc == $past(acc) + $past(prod_ext)));

  a_r4_sub_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear && op == 2'b10) |=> (acc == $past(acc) - $past(prod_ext)));

  a_r5_unsigned_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear && op == 2'b00 && !signed_mode) |=> (acc[ACC_W-1:PROD_W] == '0));

  a_r9_ovf_range: assert property (@(posedge clk) disable iff (!rst_n)
    ovf == (($signed(acc) > $signed({{(ACC_W-PROD_W+1){1'b0}}, {(PROD_W-1){1'b1}}})) ||
            ($signed(acc) < $signed({{(ACC_W-PROD_W+1){1'b1}}, {(PROD_W-1){1'b0}}}))));
endmodule

// File: tb/mac_unit_tb.sv
`timescale 1ns/1ps
module mac_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic        clear;
  logic        signed_mode;
  logic [15:0] a, b;
  logic [39:0] acc;
  logic        ovf;

  int total = 0;
  int bad   = 0;
  logic [39:0] model = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .clear(clear),
    .signed_mode(signed_mode), .a(a), .b(b), .acc(acc), .ovf(ovf)
  );

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic exp_ovf(input logic [39:0] v);
    longint s;
    s = longint'($signed(v));
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic logic [39:0] exp_prod(input logic [15:0] x, input logic [15:0] y,
                                           input logic s);
    longint px, py, p;
    px = s ? longint'($signed(x)) : longint'(x);
    py = s ? longint'($signed(y)) : longint'(y);
    p  = px * py;
    return p[39:0];
  endfunction

  // Drive at negedge, design registers at posedge, compare at next negedge
  task automatic do_op(input logic [1:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic s, input logic clr, input logic vld, input string tag);
    logic [39:0] p;
    op = o; a = x; b = y; signed_mode = s; clear = clr; in_valid = vld;
    p = exp_prod(x, y, s);
    if (clr) model = '0;
    else if (vld) begin
      case (o)
        2'b00: model = p;
        2'b01: model = model + p;
        2'b10: model = model - p;
        default: model = model;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, acc, model);
    check("R9 ovf", {39'd0, ovf}, {39'd0, exp_ovf(model)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [8];
    string tg;
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h7FFF;
    vals[4] = 16'h8000; vals[5] = 16'h1234; vals[6] = 16'hA5C3; vals[7] = 16'h00FF;

    rst_n = 1'b0; in_valid = 1'b1; op = 2'b01; clear = 1'b0; signed_mode = 1'b1;
    a = 16'h7FFF; b = 16'h7FFF;
    repeat (3) @(negedge clk);
    check("R1 acc in reset", acc, 40'd0);
    check("R1 ovf in reset", {39'd0, ovf}, 40'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 acc after reset", acc, 40'd0);
    check("R1 ovf after reset", {39'd0, ovf}, 40'd0);

    // Boundary sweep over both modes and all three operations (R2 R3 R4 R5)
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 3; o++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            tg = (o == 0) ? "R2 mul" : (o == 1) ? "R3 add" : "R4 sub";
            if (s == 0) tg = {tg, " R5 unsigned"}; else tg = {tg, " R5 signed"};
            do_op(o[1:0], vals[i], vals[j], s[0], 1'b0, 1'b1, tg);
          end

    // R6: clear wins over an issued multiply-add
    do_op(2'b00, 16'h4000, 16'h0003, 1'b1, 1'b0, 1'b1, "R2 preload");
    do_op(2'b01, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, "R6 clear priority");
    check("R6 zero", acc, 40'd0);

    // R7: idle cycles hold even with live operands
    do_op(2'b00, 16'h0123, 16'h0456, 1'b1, 1'b0, 1'b1, "R2 preload");
    do_op(2'b00, 16'hFFFF, 16'h8000, 1'b1, 1'b0, 1'b0, "R7 idle hold mul");
    do_op(2'b10, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b0, "R7 idle hold sub");

    // R8: reserved op code holds
    do_op(2'b11, 16'h7FFF, 16'h7FFF, 1'b1, 1'b0, 1'b1, "R8 reserved hold");
    do_op(2'b11, 16'h8000, 16'h0001, 1'b0, 1'b0, 1'b1, "R8 reserved hold");

    // R9: signed 2^30 steps cross the 32-bit range on the second add
    do_op(2'b00, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, "R6 clear");
    for (int k = 0; k < 6; k++)
      do_op(2'b01, 16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1, "R9 signed growth");
    for (int k = 0; k < 8; k++)
      do_op(2'b10, 16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1, "R9 signed descent");

    // R10: unsigned full-scale adds until the 40-bit sum wraps, then back down
    do_op(2'b00, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, "R6 clear");
    for (int k = 0; k < 300; k++)
      do_op(2'b01, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R10 wrap up");
    for (int k = 0; k < 300; k++)
      do_op(2'b10, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R10 wrap down");
    check("R10 returns to zero", acc, 40'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule